// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor. On every cycle it looks at the pending interrupts the distributor offers for this CPU and picks the most urgent one. It signals the CPU only when that interrupt is more urgent than both a programmable priority mask and the priority of the handler that is already running. Each interrupt carries an 8-bit priority, and a smaller value means more urgent. Priorities arrive packed four to a 32-bit word, so interrupt `n` uses bits `[8n+7:8n]` of the flat priority bus. Interrupt IDs are 10 bits wide. ID 1023 is the spurious answer. IDs 1020 and 1021 are reserved and are never chosen.

Software reads the acknowledge register to claim the chosen interrupt. The claim returns the interrupt's ID and pulses a claim strobe so the distributor can clear the pending bit and mark the interrupt active. It also pushes the interrupt's priority and ID onto a small stack of active priorities, and the top of that stack is the running priority. Writing the ID to the end-of-interrupt register retires the innermost handler. This pops the stack and pulses a completion strobe toward the distributor. Because of the stack, a more urgent interrupt can preempt a running handler, and the handlers then unwind in nested order.

Top module: `cpu_irq_iface`

## Requirements
- R1: After a synchronous active-low reset: `irq_o`, `claim_o`, `done_o` and `bus_rdata` are 0, control and mask read 0, running priority reads 0xFF, and highest pending reads 1023 when nothing is pending.
- R2: Register reads are registered, so `bus_rdata` shows the value one clock after the read is accepted. Control (offset 0x00) keeps bit 0 as the enable. Mask (offset 0x04) keeps bits 7:0, and higher written bits read back as 0.
- R3: Among pending interrupts, the one with the numerically lowest priority is chosen. Equal priorities go to the lower ID.
- R4: `irq_o` is 1 one clock after these conditions all hold: the enable is set, a pending interrupt exists, the stack is not full, and the chosen priority is strictly below both the mask and the running priority.
- R5: A read of acknowledge (0x0C) while R4's condition holds returns the chosen ID in bits 9:0. In the same edge it pulses `claim_o` with `claim_id_o` set to that ID, and the running priority (0x14) becomes that interrupt's priority.
- R6: A read of acknowledge while R4's condition fails returns 1023, leaves `claim_o` low and leaves the running priority unchanged.
- R7: A write to end-of-interrupt (0x10) whose bits 9:0 equal the ID on top of the stack pops the stack. It pulses `done_o` with `done_id_o` set to that ID, and the running priority returns to the next entry, or to 0xFF when the stack is empty.
- R8: An end-of-interrupt write with an ID other than the top entry, or with an empty stack, leaves `done_o` low and the running priority unchanged.
- R9: Highest pending (0x18) returns the ID chosen by R3 whatever the enable, mask and running priority are, or 1023 when nothing is pending.
- R10: Up to `STACK_DEPTH` handlers can nest, each preempting a less urgent one. While the stack is full, `irq_o` is 0 and an acknowledge returns 1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | NUM_IRQ | Pending interrupts forwarded to this CPU, bit n = ID n |
| prio_i | input | 8*NUM_IRQ | Packed priorities, bits [8n+7:8n] for ID n |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the read |
| irq_o | output | 1 | Interrupt request to the CPU |
| claim_o | output | 1 | One-cycle pulse: an interrupt was acknowledged |
| claim_id_o | output | 10 | ID of the acknowledged interrupt |
| done_o | output | 1 | One-cycle pulse: an interrupt was retired |
| done_id_o | output | 10 | ID of the retired interrupt |

## Verification
Every result of this block leaves through a register. Read data, the claim strobe and the running-priority change all belong to the edge that accepts an acknowledge read, and the completion strobe belongs to the edge that accepts the end-of-interrupt write. `irq_o` follows a change of pending, mask or stack state by one edge. The bench drives a request at a falling edge and samples at the next falling edge, which is exactly one rising edge later. When the irq line is checked after a change to the pending inputs, at least one further register access lies between the two, so its single edge of latency has passed.

// File: rtl/cpu_irq_pkg.sv
// Package: shared constants, register offsets and the active-stack entry
// type for the per-CPU interrupt acknowledge interface.
package cpu_irq_pkg;
    localparam int ID_W      = 10;
    localparam int PRIO_W    = 8;
    localparam int FIRST_RSV = 1020;  // IDs from here up are never delivered

    localparam logic [ID_W-1:0]   ID_SPURIOUS = 10'd1023;
    localparam logic [PRIO_W-1:0] PRIO_IDLE   = 8'hFF;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_MASK = 8'h04;
    localparam logic [7:0] OFF_ACK  = 8'h0C;
    localparam logic [7:0] OFF_EOI  = 8'h10;
    localparam logic [7:0] OFF_RUN  = 8'h14;
    localparam logic [7:0] OFF_HIPE = 8'h18;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
    } act_entry_t;
endpackage

// File: rtl/cpu_irq_select.sv
// Module: cpu_irq_select
// Purpose: combinational pick of the most urgent pending interrupt.
// Assumes: a lower priority value is more urgent; ties go to the lower ID;
// IDs at or above the first reserved ID are never eligible.
module cpu_irq_select
    import cpu_irq_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [NUM_IRQ-1:0]        pend,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio,
    output logic                      valid,
    output logic [ID_W-1:0]           id,
    output logic [PRIO_W-1:0]         best_prio
);
    logic [NUM_IRQ-1:0] elig;

    // Eligibility: the parameter decides which IDs can ever be offered.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_elig
        if (g >= FIRST_RSV) begin : g_rsv
            assign elig[g] = 1'b0;
        end else begin : g_ok
            assign elig[g] = pend[g];
        end
    end

    // Linear scan: a later ID replaces the current pick only if strictly more urgent.
    always_comb begin
        valid     = 1'b0;
        id        = '0;
        best_prio = PRIO_IDLE;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig[i] && (!valid || prio[i*PRIO_W +: PRIO_W] < best_prio)) begin
                valid     = 1'b1;
                id        = ID_W'(i);
                best_prio = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/cpu_irq_stack.sv
// Module: cpu_irq_stack
// Purpose: LIFO of active handlers (priority and ID); its top is the
// running priority.
// Assumes: the caller never pushes while full nor pops while empty; a push
// and pop in one cycle replace the top entry.
module cpu_irq_stack
    import cpu_irq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       pop,
    input  act_entry_t push_ent,
    output act_entry_t top,
    output logic       empty,
    output logic       full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    act_entry_t     mem [DEPTH];
    logic [CW-1:0]  count;
    logic [IW-1:0]  wr_idx;
    logic [IW-1:0]  top_idx;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign wr_idx  = IW'(count);
    assign top_idx = IW'(count - 1'b1);
    assign top     = empty ? '0 : mem[top_idx];

    // Stack storage and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            case ({push, pop})
                2'b10: begin
                    mem[wr_idx] <= push_ent;
                    count       <= count + 1'b1;
                end
                2'b01: count <= count - 1'b1;
                2'b11: mem[top_idx] <= push_ent;
                default: ;
            endcase
        end
    end

    p_no_push_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> !full);
    p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_push_grows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/cpu_irq_iface.sv
// Module: cpu_irq_iface (top)
// Purpose: per-CPU interrupt interface: register port, delivery gating by
// mask and running priority, acknowledge/claim and nested end-of-interrupt.
// Assumes: the distributor clears a pending bit after claim_o and keeps
// pend_i/prio_i stable relative to clk; one register access per cycle.
module cpu_irq_iface
    import cpu_irq_pkg::*;
#(
    parameter int NUM_IRQ     = 64,
    parameter int STACK_DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [7:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      irq_o,
    output logic                      claim_o,
    output logic [ID_W-1:0]           claim_id_o,
    output logic                      done_o,
    output logic [ID_W-1:0]           done_id_o
);
    logic              ctrl_en;
    logic [PRIO_W-1:0] mask_q;
    logic              sel_valid;
    logic [ID_W-1:0]   sel_id;
    logic [PRIO_W-1:0] sel_prio;
    act_entry_t        stk_top;
    act_entry_t        new_ent;
    logic              stk_empty;
    logic              stk_full;
    logic [PRIO_W-1:0] running;
    logic              deliver;
    logic              ack_hit;
    logic              take;
    logic              eoi_hit;
    logic              retire;
    logic [ID_W-1:0]   hipe_id;

    cpu_irq_select #(.NUM_IRQ(NUM_IRQ)) i_select (
        .pend      (pend_i),
        .prio      (prio_i),
        .valid     (sel_valid),
        .id        (sel_id),
        .best_prio (sel_prio)
    );

    cpu_irq_stack #(.DEPTH(STACK_DEPTH)) i_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take),
        .pop      (retire),
        .push_ent (new_ent),
        .top      (stk_top),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    // Delivery condition shared by the irq line and the acknowledge path.
    assign running = stk_empty ? PRIO_IDLE : stk_top.prio;
    assign deliver = ctrl_en && sel_valid && !stk_full
                   && (sel_prio < mask_q) && (sel_prio < running);
    assign ack_hit = bus_rd && (bus_addr == OFF_ACK);
    assign take    = ack_hit && deliver;
    assign eoi_hit = bus_wr && (bus_addr == OFF_EOI);
    assign retire  = eoi_hit && !stk_empty && (stk_top.id == bus_wdata[ID_W-1:0]);
    assign new_ent = '{prio: sel_prio, id: sel_id};
    assign hipe_id = sel_valid ? sel_id : ID_SPURIOUS;

    // Writable configuration: enable bit and priority mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            mask_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFF_CTRL) ctrl_en <= bus_wdata[0];
            if (bus_addr == OFF_MASK) mask_q  <= bus_wdata[PRIO_W-1:0];
        end
    end

    // Registered read data mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                OFF_CTRL: bus_rdata <= {31'd0, ctrl_en};
                OFF_MASK: bus_rdata <= {24'd0, mask_q};
                OFF_ACK:  bus_rdata <= {22'd0, (deliver ? sel_id : ID_SPURIOUS)};
                OFF_RUN:  bus_rdata <= {24'd0, running};
                OFF_HIPE: bus_rdata <= {22'd0, hipe_id};
                default:  bus_rdata <= '0;
            endcase
        end
    end

    // Registered irq line and distributor strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o      <= 1'b0;
            claim_o    <= 1'b0;
            claim_id_o <= '0;
            done_o     <= 1'b0;
            done_id_o  <= '0;
        end else begin
            irq_o   <= deliver;
            claim_o <= take;
            done_o  <= retire;
            if (take)   claim_id_o <= sel_id;
            if (retire) done_id_o  <= stk_top.id;
        end
    end

    p_claim_from_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |-> $past(bus_rd && bus_addr == OFF_ACK));
    p_no_claim_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !deliver) |=> !claim_o);
    p_done_from_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(bus_wr && bus_addr == OFF_EOI));
    p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(ctrl_en));
    p_strobes_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |=> !claim_o);
endmodule

// File: tb/test_cpu_irq_iface.sv
`timescale 1ns/1ps
module test_cpu_irq_iface;
    localparam int N = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pend = '0;
    logic [N*8-1:0] prio = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_o;
    logic          claim_o;
    logic [9:0]    claim_id_o;
    logic          done_o;
    logic [9:0]    done_id_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    cpu_irq_iface #(.NUM_IRQ(N), .STACK_DEPTH(4)) i_cpu_irq_iface (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .prio_i(prio),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .claim_o(claim_o), .claim_id_o(claim_id_o),
        .done_o(done_o), .done_id_o(done_id_o)
    );

    typedef struct packed {
        logic [6:0]  ia; logic [7:0] pa;
        logic [6:0]  ib; logic [7:0] pb;
        logic [6:0]  ic; logic [7:0] pc;
        logic [7:0]  mask;
        logic [9:0]  exp_id;
        logic        exp_irq;
    } vec_t;

    // ID 127 marks an unused slot.
    localparam vec_t VECS [8] = '{
        '{7'd5,  8'h40, 7'd9,   8'h30, 7'd20,  8'h50, 8'hFF, 10'd9,    1'b1},
        '{7'd5,  8'h30, 7'd9,   8'h30, 7'd20,  8'h50, 8'hFF, 10'd5,    1'b1},
        '{7'd40, 8'h10, 7'd3,   8'h20, 7'd63,  8'h10, 8'hFF, 10'd40,   1'b1},
        '{7'd40, 8'h10, 7'd127, 8'h00, 7'd127, 8'h00, 8'h10, 10'd40,   1'b0},
        '{7'd7,  8'h80, 7'd127, 8'h00, 7'd127, 8'h00, 8'h81, 10'd7,    1'b1},
        '{7'd0,  8'hFE, 7'd127, 8'h00, 7'd127, 8'h00, 8'hFF, 10'd0,    1'b1},
        '{7'd0,  8'hFF, 7'd127, 8'h00, 7'd127, 8'h00, 8'hFF, 10'd0,    1'b0},
        '{7'd127,8'h00, 7'd127, 8'h00, 7'd127, 8'h00, 8'hFF, 10'd1023, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_irq(input int id, input logic [7:0] p);
        if (id < N) begin
            pend[id] = 1'b1;
            prio[id*8 +: 8] = p;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired before completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 irq_o", {31'd0, irq_o}, 32'd0);
        chk("R1 rdata", bus_rdata, 32'd0);
        rd(8'h00, rv); chk("R1 ctrl", rv, 32'd0);
        rd(8'h04, rv); chk("R1 mask", rv, 32'd0);
        rd(8'h14, rv); chk("R1 running", rv, 32'hFF);
        rd(8'h18, rv); chk("R1 hipe", rv, 32'd1023);

        // R2: register write/read-back
        wr(8'h00, 32'h0000_0001);
        rd(8'h00, rv); chk("R2 ctrl", rv, 32'd1);
        wr(8'h04, 32'hFFFF_FF37);
        rd(8'h04, rv); chk("R2 mask", rv, 32'h37);

        // R3/R4/R9: vector table
        foreach (VECS[k]) begin
            pend = '0;
            set_irq(int'(VECS[k].ia), VECS[k].pa);
            set_irq(int'(VECS[k].ib), VECS[k].pb);
            set_irq(int'(VECS[k].ic), VECS[k].pc);
            wr(8'h04, {24'd0, VECS[k].mask});
            rd(8'h18, rv);
            chk("R3 R9 pick", rv, {22'd0, VECS[k].exp_id});
            chk("R4 irq", {31'd0, irq_o}, {31'd0, VECS[k].exp_irq});
        end

        // R4/R6/R9: disabled interface
        pend = '0;
        wr(8'h00, 32'd0);
        set_irq(8, 8'h10);
        wr(8'h04, 32'hFF);
        @(negedge clk);
        chk("R4 disabled irq", {31'd0, irq_o}, 32'd0);
        rd(8'h18, rv); chk("R9 hipe disabled", rv, 32'd8);
        rd(8'h0C, rv); chk("R6 ack disabled", rv, 32'd1023);
        chk("R6 no claim", {31'd0, claim_o}, 32'd0);
        wr(8'h00, 32'd1);
        pend = '0;

        // R5/R6/R7/R8: nesting
        set_irq(10, 8'h60);
        rd(8'h0C, rv); chk("R5 ack id", rv, 32'd10);
        chk("R5 claim", {21'd0, claim_o, claim_id_o}, {21'd0, 1'b1, 10'd10});
        pend[10] = 1'b0;
        rd(8'h14, rv); chk("R5 running", rv, 32'h60);
        set_irq(30, 8'h70);
        rd(8'h0C, rv); chk("R6 ack masked by running", rv, 32'd1023);
        chk("R6 no claim", {31'd0, claim_o}, 32'd0);
        rd(8'h14, rv); chk("R6 running kept", rv, 32'h60);
        set_irq(12, 8'h20);
        @(negedge clk);
        @(negedge clk);
        chk("R10 preempt irq", {31'd0, irq_o}, 32'd1);
        rd(8'h0C, rv); chk("R10 preempt ack", rv, 32'd12);
        pend[12] = 1'b0;
        rd(8'h14, rv); chk("R5 nested running", rv, 32'h20);
        wr(8'h10, 32'd10);
        chk("R8 mismatch no done", {31'd0, done_o}, 32'd0);
        rd(8'h14, rv); chk("R8 running kept", rv, 32'h20);
        wr(8'h10, 32'd12);
        chk("R7 done", {21'd0, done_o, done_id_o}, {21'd0, 1'b1, 10'd12});
        rd(8'h14, rv); chk("R7 running restored", rv, 32'h60);
        wr(8'h10, 32'd10);
        chk("R7 done outer", {21'd0, done_o, done_id_o}, {21'd0, 1'b1, 10'd10});
        rd(8'h14, rv); chk("R7 running idle", rv, 32'hFF);
        chk("R4 waiting irq delivered", {31'd0, irq_o}, 32'd1);
        pend = '0;

        // R10: full stack
        for (int j = 1; j <= 4; j++) begin
            set_irq(j, 8'(8'h60 - 8'(j * 16)));
            rd(8'h0C, rv); chk("R10 fill ack", rv, 32'(j));
            pend[j] = 1'b0;
        end
        set_irq(5, 8'h05);
        @(negedge clk);
        @(negedge clk);
        chk("R10 full irq", {31'd0, irq_o}, 32'd0);
        rd(8'h0C, rv); chk("R10 full ack", rv, 32'd1023);
        pend[5] = 1'b0;
        for (int j = 4; j >= 1; j--) begin
            wr(8'h10, 32'(j));
            chk("R7 unwind done", {31'd0, done_o}, 32'd1);
        end
        rd(8'h14, rv); chk("R7 unwound running", rv, 32'hFF);
        wr(8'h10, 32'd1);
        chk("R8 empty no done", {31'd0, done_o}, 32'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule